// File: doc/BRIEF.md
# Validated SPI Message Ring Receiver

This block is an SPI slave receiver. It collects fixed-size messages of nine 16-bit words. The first eight words are payload and the ninth is a check word. A CRC runs bit by bit as the payload shifts in, and the check word is compared against it when the last bit arrives. Only messages whose check word matches are released to readers. A message that fails the check is dropped and counted. A message cut short by chip select going high is discarded without any side effect.

The block also runs a free-running time counter. Each message is stamped with the counter value taken when chip select goes low. The stamp is stored with the payload, so a reader can compute the age of the data by subtracting the stamp from `now_o`.

There are two read paths. The first is a low-latency port that always shows the newest accepted message. It updates on the cycle after the check passes. The second is a show-ahead FIFO port over a 32-entry ring, drained in arrival order by a slow periodic reader. When the ring is full, the oldest entry is overwritten and a sticky overflow flag is raised.

Top module: `spi_msg_ring`

## Requirements
- R1: A frame is 144 bits in SPI mode 0 (MOSI sampled on rising SCLK, active-low chip select), each word MSB first. Word 1 appears in `latest_data_o[127:112]` and `fifo_data_o[127:112]`, and word 8 in bits [15:0].
- R2: The CRC uses polynomial 0x1021 with initial value 0xFFFF, no reflection and no final XOR, run over the 128 payload bits in shift order. When word 9 equals this CRC, the message is written to the ring and to the newest-message port.
- R3: When word 9 does not match, the message is not stored. `crc_err_o` pulses high for exactly one cycle and `err_cnt_o` increments, saturating at all ones.
- R4: If chip select rises before 144 bits, the message is discarded: ring count, newest port and error count are all unchanged. SCLK edges after the 144th bit, while chip select stays low, are ignored.
- R5: The stored timestamp equals the `now_o` value seen in the cycle in which `cs_ni` is driven low, plus 2 (synchronizer latency). `now_o` increments by one every clock from 0 after reset.
- R6: `latest_valid_o` goes high at the first accepted message. `latest_data_o` and `latest_ts_o` then change only when a new message is accepted, and always show the most recently accepted one.
- R7: The FIFO port shows the oldest stored entry while `fifo_empty_o` is low. A cycle with `fifo_rd_i` high removes that entry. A read while empty has no effect.
- R8: A message accepted while the ring holds 32 entries replaces the oldest entry. The count stays at 32 and `ovf_o` goes high. `ovf_o` stays high until a cycle with `ovf_clr_i` high.
- R9: After reset, `latest_valid_o` is low, `fifo_empty_o` is high, `fifo_count_o`, `err_cnt_o` and `ovf_o` are zero, and `crc_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock, mode 0 |
| mosi_i | input | 1 | SPI serial data in |
| cs_ni | input | 1 | SPI chip select, active low |
| now_o | output | 32 | Free-running time counter |
| latest_valid_o | output | 1 | Newest-message port holds a message |
| latest_data_o | output | 128 | Payload of newest accepted message |
| latest_ts_o | output | 32 | Timestamp of newest accepted message |
| fifo_rd_i | input | 1 | Pop the oldest ring entry |
| fifo_empty_o | output | 1 | Ring holds no entries |
| fifo_data_o | output | 128 | Payload of oldest ring entry |
| fifo_ts_o | output | 32 | Timestamp of oldest ring entry |
| fifo_count_o | output | 6 | Entries held in the ring |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| ovf_o | output | 1 | Sticky ring overwrite flag |
| crc_err_o | output | 1 | One-cycle pulse on a check-word mismatch |
| err_cnt_o | output | 16 | Saturating count of check-word mismatches |

## Verification
The assertions check, on every cycle:
- the bit counter never runs past the frame length;
- pass and fail pulses never coincide;
- the error counter holds once it saturates;
- the ring count never exceeds the depth;
- the overflow flag holds until cleared;
- a read of an empty ring leaves the count at zero;
- the newest-message port stays stable when no message passes.

Only the bench scenarios can show the rest. These are the CRC value and the word order of accepted payloads, and the exact timestamp of each message. They also cover dropping of corrupted, truncated and over-long frames, FIFO arrival order, and which entry survives when 34 messages arrive into a 32-entry ring.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
  localparam int WORD_W     = 16;
  localparam int DATA_WORDS = 8;
  localparam int PAY_W      = WORD_W * DATA_WORDS;
  localparam int FRAME_BITS = PAY_W + WORD_W;
  localparam int TS_W       = 32;
  localparam int ERR_W      = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_INIT = 16'hFFFF;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [PAY_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/msg_deframer.sv
module msg_deframer
  import spi_msg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic            sclk_i,
  input  logic            mosi_i,
  input  logic [TS_W-1:0] now_i,
  output logic            ok_o,
  output logic            bad_o,
  output msg_t            msg_o
);
  localparam int BC_W = $clog2(FRAME_BITS + 1);
  localparam logic [BC_W-1:0] BC_PAY  = BC_W'(PAY_W);
  localparam logic [BC_W-1:0] BC_END  = BC_W'(FRAME_BITS);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c, input logic b);
    logic fb;
    fb = c[WORD_W-1] ^ b;
    return {c[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  logic              cs_q, sclk_q, active_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [WORD_W-1:0] crc_q, rx_crc_q;
  logic [PAY_W-1:0]  pay_q;
  logic [TS_W-1:0]   ts_q;
  logic              cs_fall, sclk_rise;
  logic [WORD_W-1:0] rx_full;

  assign cs_fall   = cs_q & ~cs_n_i;
  assign sclk_rise = sclk_i & ~sclk_q;
  assign rx_full   = {rx_crc_q[WORD_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      crc_q     <= CRC_INIT;
      rx_crc_q  <= '0;
      pay_q     <= '0;
      ts_q      <= '0;
      ok_o      <= 1'b0;
      bad_o     <= 1'b0;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
      ok_o   <= 1'b0;
      bad_o  <= 1'b0;
      if (cs_fall) begin
        active_q  <= 1'b1;
        bit_cnt_q <= '0;
        crc_q     <= CRC_INIT;
        ts_q      <= now_i;
      end else if (cs_n_i) begin
        active_q <= 1'b0;  // early rise aborts: nothing committed
      end else if (active_q && sclk_rise && bit_cnt_q < BC_END) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q < BC_PAY) begin
          crc_q <= crc_step(crc_q, mosi_i);
          pay_q <= {pay_q[PAY_W-2:0], mosi_i};
        end else begin
          rx_crc_q <= rx_full;
          if (bit_cnt_q == BC_LAST) begin
            if (rx_full == crc_q) ok_o  <= 1'b1;
            else                  bad_o <= 1'b1;
          end
        end
      end
    end
  end

  assign msg_o.ts   = ts_q;
  assign msg_o.data = pay_q;

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= BC_END);  // R4
  AST_OK_BAD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && bad_o));  // R2
endmodule

// File: rtl/msg_ring.sv
module msg_ring
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  msg_t                       wr_msg_i,
  input  logic                       rd_i,
  output msg_t                       rd_msg_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  input  logic                       ovf_clr_i,
  output logic                       ovf_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  msg_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, rd_fire, ovf_ev;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign rd_fire = rd_i && (count_q != '0);
  assign ovf_ev  = wr_i && (count_q == CNT_FULL) && !rd_fire;

  always_comb begin
    count_d = count_q;
    if (wr_i && !ovf_ev) count_d = count_d + 1'b1;
    if (rd_fire)         count_d = count_d - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wr_ptr_q] <= wr_msg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      if (wr_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_fire || ovf_ev) rd_ptr_q <= ptr_inc(rd_ptr_q);  // skip overwritten oldest
      if (ovf_ev)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign rd_msg_o = mem[rd_ptr_q];
  assign empty_o  = (count_q == '0);
  assign count_o  = count_q;
  assign ovf_o    = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_FULL);  // R8
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);  // R8
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !wr_i) |=> (count_q == '0));  // R7
endmodule

// File: rtl/spi_msg_ring.sv
module spi_msg_ring
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  input  logic                       cs_ni,
  output logic [TS_W-1:0]            now_o,
  output logic                       latest_valid_o,
  output logic [PAY_W-1:0]           latest_data_o,
  output logic [TS_W-1:0]            latest_ts_o,
  input  logic                       fifo_rd_i,
  output logic                       fifo_empty_o,
  output logic [PAY_W-1:0]           fifo_data_o,
  output logic [TS_W-1:0]            fifo_ts_o,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count_o,
  input  logic                       ovf_clr_i,
  output logic                       ovf_o,
  output logic                       crc_err_o,
  output logic [ERR_W-1:0]           err_cnt_o
);
  logic [2:0]       sync_q;
  logic             msg_ok, msg_bad;
  msg_t             rx_msg, fifo_msg, latest_q;
  logic             latest_vld_q;
  logic [TS_W-1:0]  now_q;
  logic [ERR_W-1:0] err_cnt_q;

  spi_in_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (sync_q)
  );

  msg_deframer u_deframer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_n_i(sync_q[2]),
    .sclk_i(sync_q[1]),
    .mosi_i(sync_q[0]),
    .now_i (now_q),
    .ok_o  (msg_ok),
    .bad_o (msg_bad),
    .msg_o (rx_msg)
  );

  msg_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (msg_ok),
    .wr_msg_i (rx_msg),
    .rd_i     (fifo_rd_i),
    .rd_msg_o (fifo_msg),
    .empty_o  (fifo_empty_o),
    .count_o  (fifo_count_o),
    .ovf_clr_i(ovf_clr_i),
    .ovf_o    (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q        <= '0;
      latest_q     <= '0;
      latest_vld_q <= 1'b0;
      err_cnt_q    <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (msg_ok) begin
        latest_q     <= rx_msg;
        latest_vld_q <= 1'b1;
      end
      if (msg_bad && err_cnt_q != '1) err_cnt_q <= err_cnt_q + 1'b1;
    end
  end

  assign now_o          = now_q;
  assign latest_valid_o = latest_vld_q;
  assign latest_data_o  = latest_q.data;
  assign latest_ts_o    = latest_q.ts;
  assign fifo_data_o    = fifo_msg.data;
  assign fifo_ts_o      = fifo_msg.ts;
  assign crc_err_o      = msg_bad;
  assign err_cnt_o      = err_cnt_q;

  AST_ERR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_q == '1) |=> (err_cnt_q == '1));  // R3
  AST_LATEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_ok |=> ($stable(latest_q) && $stable(latest_vld_q)));  // R6
endmodule

// File: tb/spi_msg_ring_tb.sv
module spi_msg_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int HALF_SCK   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, fifo_rd = 1'b0, ovf_clr = 1'b0;
  logic [31:0]  now_o, latest_ts, fifo_ts;
  logic [127:0] latest_data, fifo_data;
  logic         latest_valid, fifo_empty, ovf, crc_err;
  logic [5:0]   fifo_count;
  logic [15:0]  err_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_msg_ring #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_ni(cs_n),
    .now_o(now_o), .latest_valid_o(latest_valid), .latest_data_o(latest_data),
    .latest_ts_o(latest_ts), .fifo_rd_i(fifo_rd), .fifo_empty_o(fifo_empty),
    .fifo_data_o(fifo_data), .fifo_ts_o(fifo_ts), .fifo_count_o(fifo_count),
    .ovf_clr_i(ovf_clr), .ovf_o(ovf), .crc_err_o(crc_err), .err_cnt_o(err_cnt)
  );

  int errors = 0, checks = 0, seen_bad = 0, exp_bad = 0;
  logic [159:0] sb_q[$];
  logic [159:0] model_q[$];
  logic         have_last = 1'b0;
  logic [31:0]  last_ts = '0;

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [15:0] ref_crc(input logic [127:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 127; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [127:0] mk_data(input int k);
    logic [31:0] u = 32'(k);
    return {32'h1111_0000 + u, 32'hCAFE_0000 ^ u, u * 32'h0101_0101, 32'hDEAD_BEEF - u};
  endfunction

  // driver: pushes expected items, then shifts the frame out
  task automatic send(input logic [127:0] d, input logic [15:0] cw, input int nbits, input int extra);
    logic [143:0] fr = {d, cw};
    logic [31:0]  t;
    bit good;
    @(negedge clk);
    cs_n = 1'b0;
    t = now_o + 32'd2;  // R5
    good = (nbits == 144) && (cw == ref_crc(d));
    if (good) begin
      sb_q.push_back({t, d});
      model_q.push_back({t, d});
      if (model_q.size() > DEPTH) void'(model_q.pop_front());
    end
    if (nbits == 144 && !good) exp_bad++;
    repeat (HALF_SCK) @(negedge clk);
    for (int i = 0; i < nbits + extra; i++) begin
      mosi = (i < 144) ? fr[143 - i] : 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic pop_check(input string req);
    @(negedge clk);
    check(!fifo_empty, req, {159'd0, fifo_empty}, 160'd0);
    if (model_q.size() > 0)
      check({fifo_ts, fifo_data} == model_q[0], req, {fifo_ts, fifo_data}, model_q[0]);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    if (model_q.size() > 0) void'(model_q.pop_front());
  endtask

  // monitor: compares every newest-port update against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (crc_err) seen_bad++;
      if (latest_valid && (!have_last || latest_ts != last_ts)) begin
        have_last = 1'b1;
        last_ts   = latest_ts;
        if (sb_q.size() == 0) begin
          check(1'b0, "R6 unexpected update", {latest_ts, latest_data}, 160'd0);
        end else begin
          // R1 R2 R5 R6: payload order, accepted CRC, timestamp
          check({latest_ts, latest_data} == sb_q[0], "R2/R5/R6 newest message",
                {latest_ts, latest_data}, sb_q[0]);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    check(1'b0, "watchdog", 160'd0, 160'd1);
    finish_run();
  end

  initial begin
    logic [127:0] d;
    logic [31:0]  ts_hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!latest_valid && fifo_empty && fifo_count == 0 && err_cnt == 0 && !ovf && !crc_err,
          "R9 reset", {latest_valid, fifo_empty, fifo_count, err_cnt, ovf, crc_err}, {1'b0, 1'b1, 6'd0, 16'd0, 1'b0, 1'b0});

    for (int k = 0; k < 3; k++) begin
      d = mk_data(k);
      send(d, ref_crc(d), 144, 0);
    end
    check(latest_data[127:112] == 16'h1111 && latest_data[15:0] == d[15:0], "R1 word position",
          {32'd0, latest_data}, {32'd0, d});
    check(fifo_count == 3, "R2 three stored", {154'd0, fifo_count}, 160'd3);

    // R3 corrupted check word
    ts_hold = latest_ts;
    d = mk_data(100);
    send(d, ref_crc(d) ^ 16'h0040, 144, 0);
    check(err_cnt == 1, "R3 err count", {144'd0, err_cnt}, 160'd1);
    check(seen_bad == 1, "R3 one pulse", 160'(seen_bad), 160'd1);
    check(fifo_count == 3 && latest_ts == ts_hold, "R3 not stored", {122'd0, fifo_count, latest_ts}, {122'd0, 6'd3, ts_hold});

    // R4 truncated frame
    d = mk_data(200);
    send(d, ref_crc(d), 70, 0);
    check(fifo_count == 3 && latest_ts == ts_hold && err_cnt == 1, "R4 abort",
          {106'd0, fifo_count, err_cnt, latest_ts}, {106'd0, 6'd3, 16'd1, ts_hold});

    // R4 trailing clocks ignored
    d = mk_data(3);
    send(d, ref_crc(d), 144, 20);
    check(fifo_count == 4 && err_cnt == 1, "R4 extra bits", {138'd0, fifo_count, err_cnt}, {138'd0, 6'd4, 16'd1});

    // R7 FIFO order
    for (int k = 0; k < 4; k++) pop_check("R7 fifo order");
    @(negedge clk);
    check(fifo_empty && fifo_count == 0, "R7 drained", {153'd0, fifo_empty, fifo_count}, {153'd0, 1'b1, 6'd0});
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    @(negedge clk);
    check(fifo_empty && fifo_count == 0, "R7 empty read ignored", {153'd0, fifo_empty, fifo_count}, {153'd0, 1'b1, 6'd0});

    // R8 overflow: 34 into 32
    for (int k = 10; k < 44; k++) begin
      d = mk_data(k);
      send(d, ref_crc(d), 144, 0);
    end
    check(ovf && fifo_count == 32, "R8 full overwrite", {153'd0, ovf, fifo_count}, {153'd0, 1'b1, 6'd32});
    check(fifo_data == mk_data(12), "R8 oldest dropped", {32'd0, fifo_data}, {32'd0, mk_data(12)});
    for (int k = 0; k < 32; k++) pop_check("R8 drain after overwrite");
    @(negedge clk);
    check(ovf && fifo_empty, "R8 flag sticky", {158'd0, ovf, fifo_empty}, {158'd0, 1'b1, 1'b1});
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    @(negedge clk);
    check(!ovf, "R8 flag cleared", {159'd0, ovf}, 160'd0);

    check(sb_q.size() == 0, "R6 all updates seen", 160'(sb_q.size()), 160'd0);
    check(seen_bad == exp_bad, "R3 pulse total", 160'(seen_bad), 160'(exp_bad));
    finish_run();
  end
endmodule